// File: doc/BRIEF.md
# Sprite Fetch Slot Sequencer

This block runs the memory-access slot that a raster video controller spends on one sprite in every scan line. The fast clock ticks once per bus half-cycle, so a slot is four clocks long. The first half always reads the sprite's pointer byte. The next three halves supply the three bytes that go into the sprite's 24-bit shift register. Each of those bytes is either a real fetch from sprite memory or a substitute. A real fetch happens when sprite DMA is running. When DMA is not running, the controller-owned half performs a dummy read of the last byte of the bank, and each processor-owned half returns whatever the internal data bus holds. That bus value floats high, to 0xFF, when nothing drives it.

The block also derives the display timing from two compares. One compares the sprite's Y position with the raster line; the other compares its X position with a fixed threshold. Normally the display starts on the line after the Y match. A sprite placed at the right edge (X of 0x164 or more) turns its display on in the matching line itself, before any DMA has run. The slot in that line therefore loads a bus artifact: the floating bus value, then the idle byte, then the floating bus value again.

Data moves at a fixed raster cadence, and neither side can stall it. The memory port is a read strobe with an address, and the data must be returned in the same half-cycle. The loaded register is announced by a one-clock `load_strobe`, which works as a valid. No ready exists, because a stalled slot would break the raster timing. A consumer must take `sprite_data` while the strobe is high, and `sprite_data` then holds its value until the next load. The controlling strobes `line_start`, `cmp_strobe` and `slot_go` arrive in distinct clocks. A slot is never started while an earlier slot is still running.

Top module: `sprite_fetch_slot`

## Requirements
- R1: After reset, `disp_en`, `dma_active` and `load_strobe` are 0 and `sprite_data` is 0.
- R2: In the clock where `slot_go` starts a slot (half 0), `mem_rd` and `bus_owner` are 1 and `mem_addr` = {`bank_sel`, `vm_base`, 10'h3F8 + SPR_IDX}; the byte read there is kept as the sprite pointer.
- R3: When `cmp_strobe` finds `sprite_en`=1, DMA idle and {1'b0,`y_pos`} = `raster_line`, and `x_pos` < 0x164, then `disp_en` stays 0 for the rest of the line. `dma_active` and `disp_en` both become 1 one clock after the next `line_start`. `disp_en` is 1 whenever `dma_active` is 1.
- R4: When the same compare hits with `x_pos` >= 0x164, `disp_en` becomes 1 one clock after `cmp_strobe`, while `dma_active` stays 0 until the next `line_start`.
- R5: In a slot without DMA, halves 1 and 3 have `bus_owner`=0 and `mem_rd`=0. Half 2 has `mem_rd`=1 and `mem_addr` = {`bank_sel`, 14'h3FFF}.
- R6: A slot with display on but DMA off loads `sprite_data` = {`bus_float` in half 1, the idle byte, `bus_float` in half 3}. Bits 23:16 hold the first byte.
- R7: In a DMA slot, all four halves have `bus_owner`=1 and `mem_rd`=1. Halves 1 to 3 read {`bank_sel`, pointer, c}, {.., c+1} and {.., c+2}, where c is the 6-bit byte counter. The counter is 0 when DMA is armed.
- R8: `load_strobe` is high for exactly one clock, four clocks after the `slot_go` clock. It fires only if `disp_en` was 1 in half 3 of that slot.
- R9: Without Y expansion, after 21 DMA slots the counter reaches 63, and `dma_active` and `disp_en` drop one clock after half 3 of the 21st slot.
- R10: With `y_expand`=1, each group of three bytes is fetched in two consecutive DMA slots, so DMA lasts 42 slots.
- R11: With `sprite_en`=0 a Y match arms nothing: `dma_active` and `disp_en` stay 0 across the next line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sprite_en | input | 1 | Sprite enable, gates arming |
| y_expand | input | 1 | Repeat each data line twice |
| x_pos | input | 9 | Sprite X position |
| y_pos | input | 8 | Sprite Y position |
| raster_line | input | 9 | Current raster line |
| line_start | input | 1 | One-clock pulse at start of a line |
| cmp_strobe | input | 1 | One-clock pulse: perform Y compare |
| slot_go | input | 1 | One-clock pulse: first half of the slot |
| bank_sel | input | 2 | 16 KB bank select (upper address bits) |
| vm_base | input | 4 | Video matrix base, 1 KB units |
| bus_float | input | 8 | Internal bus value on processor halves (0xFF when undriven) |
| mem_rd | output | 1 | Memory read strobe this half |
| mem_addr | output | 16 | Memory address this half |
| mem_rdata | input | 8 | Read data, same half |
| bus_owner | output | 1 | 1 when the controller owns the current slot half |
| dma_active | output | 1 | Sprite DMA running |
| disp_en | output | 1 | Sprite display enabled |
| load_strobe | output | 1 | One-clock valid for `sprite_data` |
| sprite_data | output | 24 | Loaded shift-register value |

## Verification
Several properties are checked in every clock. Half 0 must read the pointer. No memory read may happen while the processor owns the bus. A non-DMA half 2 must use the idle address. A running DMA must own the whole slot. The load strobe must be a single pulse right after half 3, and DMA must never run with the display off. The same-line display start is also checked against the raw compare inputs. Some behaviour needs whole scenarios from the bench: the exact byte values and their order in the loaded register, the counter's progress across lines, the 21-slot and 42-slot DMA lengths, and the artifact pattern with injected bus values.

// File: rtl/sprite_fetch_pkg.sv
package sprite_fetch_pkg;
  typedef enum logic [1:0] {
    HALF_PTR = 2'd0,
    HALF_D0  = 2'd1,
    HALF_D1  = 2'd2,
    HALF_D2  = 2'd3
  } half_e;

  typedef struct packed {
    logic  active;
    half_e half;
  } slot_pos_t;
endpackage

// File: rtl/sprite_slot_timer.sv
module sprite_slot_timer
  import sprite_fetch_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      slot_go,
  output slot_pos_t pos,
  output logic      slot_end
);
  logic  busy_q;
  half_e ph_q;

  always_comb begin
    if (busy_q)       pos = '{active: 1'b1, half: ph_q};
    else if (slot_go) pos = '{active: 1'b1, half: HALF_PTR};
    else              pos = '{active: 1'b0, half: HALF_PTR};
  end

  assign slot_end = pos.active && (pos.half == HALF_D2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= HALF_PTR;
    end else if (!busy_q) begin
      if (slot_go) begin
        busy_q <= 1'b1;
        ph_q   <= HALF_D0;
      end
    end else begin
      if (ph_q == HALF_D2) busy_q <= 1'b0;
      ph_q <= half_e'(ph_q + 2'd1);
    end
  end
endmodule

// File: rtl/sprite_dma_ctrl.sv
module sprite_dma_ctrl
  import sprite_fetch_pkg::*;
#(
  parameter int XPOS_W      = 9,
  parameter int YPOS_W      = 8,
  parameter int LINE_W      = 9,
  parameter int X_SAME_LINE = 'h164,
  parameter int BYTES_TOTAL = 63,
  localparam int CNT_W      = $clog2(BYTES_TOTAL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sprite_en,
  input  logic              y_expand,
  input  logic [XPOS_W-1:0] x_pos,
  input  logic [YPOS_W-1:0] y_pos,
  input  logic [LINE_W-1:0] raster_line,
  input  logic              cmp_strobe,
  input  logic              line_start,
  input  slot_pos_t         pos,
  output logic              dma_active,
  output logic              disp_en,
  output logic [CNT_W-1:0]  cnt
);
  localparam logic [CNT_W-1:0]  LAST_C  = CNT_W'(BYTES_TOTAL);
  localparam logic [XPOS_W-1:0] X_EDGE  = XPOS_W'(X_SAME_LINE);

  logic             pend_q;
  logic             rep_q;
  logic [CNT_W-1:0] cnt_start_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             y_hit;

  assign y_hit   = (LINE_W'(y_pos) == raster_line);
  assign cnt_inc = cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      rep_q       <= 1'b0;
      dma_active  <= 1'b0;
      disp_en     <= 1'b0;
      cnt         <= '0;
      cnt_start_q <= '0;
    end else if (cmp_strobe && sprite_en && !dma_active && !pend_q && y_hit) begin
      pend_q <= 1'b1;
      cnt    <= '0;
      rep_q  <= 1'b0;
      if (x_pos >= X_EDGE) disp_en <= 1'b1;
    end else if (line_start && pend_q) begin
      pend_q     <= 1'b0;
      dma_active <= 1'b1;
      disp_en    <= 1'b1;
    end else if (pos.active && dma_active) begin
      unique case (pos.half)
        HALF_PTR: cnt_start_q <= cnt;
        HALF_D0, HALF_D1: cnt <= cnt_inc;
        HALF_D2: begin
          if (y_expand && !rep_q) begin
            cnt   <= cnt_start_q;
            rep_q <= 1'b1;
          end else begin
            rep_q <= 1'b0;
            cnt   <= cnt_inc;
            if (cnt_inc == LAST_C) begin
              dma_active <= 1'b0;
              disp_en    <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sprite_fetch_path.sv
module sprite_fetch_path
  import sprite_fetch_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int VM_W    = 4,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 6,
  parameter int SPR_IDX = 0,
  localparam int LOC_W  = VM_W + 10,
  localparam int ADDR_W = BANK_W + LOC_W,
  localparam int SR_W   = 3 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_pos_t         pos,
  input  logic              dma_active,
  input  logic              disp_en,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [VM_W-1:0]   vm_base,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] bus_float,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              bus_owner,
  output logic [SR_W-1:0]   sprite_data,
  output logic              load_strobe
);
  localparam logic [9:0] PTR_OFS = 10'h3F8 + 10'(SPR_IDX);

  logic [DATA_W-1:0] ptr_q, b0_q, b1_q, byte_now;

  always_comb begin
    bus_owner = 1'b0;
    mem_addr  = {bank_sel, {LOC_W{1'b1}}};
    if (pos.active) begin
      unique case (pos.half)
        HALF_PTR: begin
          bus_owner = 1'b1;
          mem_addr  = {bank_sel, vm_base, PTR_OFS};
        end
        HALF_D1: begin
          bus_owner = 1'b1;
          mem_addr  = dma_active ? {bank_sel, ptr_q, cnt}
                                 : {bank_sel, {LOC_W{1'b1}}};
        end
        default: begin
          bus_owner = dma_active;
          mem_addr  = {bank_sel, ptr_q, cnt};
        end
      endcase
    end
  end

  assign mem_rd   = bus_owner;
  assign byte_now = bus_owner ? mem_rdata : bus_float;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q       <= '0;
      b0_q        <= '0;
      b1_q        <= '0;
      sprite_data <= '0;
      load_strobe <= 1'b0;
    end else begin
      load_strobe <= 1'b0;
      if (pos.active) begin
        unique case (pos.half)
          HALF_PTR: ptr_q <= mem_rdata;
          HALF_D0:  b0_q  <= byte_now;
          HALF_D1:  b1_q  <= byte_now;
          HALF_D2: if (disp_en) begin
            sprite_data <= {b0_q, b1_q, byte_now};
            load_strobe <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sprite_fetch_slot.sv
module sprite_fetch_slot
  import sprite_fetch_pkg::*;
#(
  parameter int SPR_IDX     = 0,
  parameter int BANK_W      = 2,
  parameter int VM_W        = 4,
  parameter int DATA_W      = 8,
  parameter int XPOS_W      = 9,
  parameter int YPOS_W      = 8,
  parameter int LINE_W      = 9,
  parameter int X_SAME_LINE = 'h164,
  parameter int BYTES_TOTAL = 63,
  localparam int CNT_W      = $clog2(BYTES_TOTAL + 1),
  localparam int ADDR_W     = BANK_W + VM_W + 10,
  localparam int SR_W       = 3 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sprite_en,
  input  logic              y_expand,
  input  logic [XPOS_W-1:0] x_pos,
  input  logic [YPOS_W-1:0] y_pos,
  input  logic [LINE_W-1:0] raster_line,
  input  logic              line_start,
  input  logic              cmp_strobe,
  input  logic              slot_go,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [VM_W-1:0]   vm_base,
  input  logic [DATA_W-1:0] bus_float,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              bus_owner,
  output logic              dma_active,
  output logic              disp_en,
  output logic              load_strobe,
  output logic [SR_W-1:0]   sprite_data
);
  slot_pos_t        pos;
  logic             slot_end;
  logic [CNT_W-1:0] cnt;

  sprite_slot_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_go  (slot_go),
    .pos      (pos),
    .slot_end (slot_end)
  );

  sprite_dma_ctrl #(
    .XPOS_W      (XPOS_W),
    .YPOS_W      (YPOS_W),
    .LINE_W      (LINE_W),
    .X_SAME_LINE (X_SAME_LINE),
    .BYTES_TOTAL (BYTES_TOTAL)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sprite_en   (sprite_en),
    .y_expand    (y_expand),
    .x_pos       (x_pos),
    .y_pos       (y_pos),
    .raster_line (raster_line),
    .cmp_strobe  (cmp_strobe),
    .line_start  (line_start),
    .pos         (pos),
    .dma_active  (dma_active),
    .disp_en     (disp_en),
    .cnt         (cnt)
  );

  sprite_fetch_path #(
    .BANK_W  (BANK_W),
    .VM_W    (VM_W),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .SPR_IDX (SPR_IDX)
  ) u_path (
    .clk         (clk),
    .rst_n       (rst_n),
    .pos         (pos),
    .dma_active  (dma_active),
    .disp_en     (disp_en),
    .bank_sel    (bank_sel),
    .vm_base     (vm_base),
    .cnt         (cnt),
    .mem_rdata   (mem_rdata),
    .bus_float   (bus_float),
    .mem_rd      (mem_rd),
    .mem_addr    (mem_addr),
    .bus_owner   (bus_owner),
    .sprite_data (sprite_data),
    .load_strobe (load_strobe)
  );

  logic unused_slot_end;
  assign unused_slot_end = slot_end;
endmodule

// File: rtl/sprite_fetch_slot_chk.sv
module sprite_fetch_slot_chk #(
  parameter int SPR_IDX     = 0,
  parameter int X_SAME_LINE = 'h164
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sprite_en,
  input logic [8:0]  x_pos,
  input logic [7:0]  y_pos,
  input logic [8:0]  raster_line,
  input logic        cmp_strobe,
  input logic        slot_go,
  input logic [1:0]  bank_sel,
  input logic [3:0]  vm_base,
  input logic        mem_rd,
  input logic [15:0] mem_addr,
  input logic        bus_owner,
  input logic        dma_active,
  input logic        disp_en,
  input logic        load_strobe,
  input logic        pend
);
  logic       c_busy, c_after;
  logic [1:0] c_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_busy  <= 1'b0;
      c_ph    <= 2'd0;
      c_after <= 1'b0;
    end else begin
      c_after <= c_busy && (c_ph == 2'd3);
      if (!c_busy) begin
        if (slot_go) begin c_busy <= 1'b1; c_ph <= 2'd1; end
      end else begin
        if (c_ph == 2'd3) c_busy <= 1'b0;
        c_ph <= c_ph + 2'd1;
      end
    end
  end

  AST_PTR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_go && !c_busy) |-> (mem_rd && bus_owner &&
      mem_addr == {bank_sel, vm_base, 10'h3F8 + 10'(SPR_IDX)})); // R2
  AST_PROC_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_owner |-> !mem_rd); // R5
  AST_IDLE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (c_busy && c_ph == 2'd2 && !dma_active) |-> (mem_rd && mem_addr[13:0] == 14'h3FFF)); // R5
  AST_DMA_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    (c_busy && dma_active) |-> bus_owner); // R7
  AST_LOAD_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |-> c_after); // R8
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |=> !load_strobe); // R8
  AST_DMA_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    dma_active |-> disp_en); // R3
  AST_SAME_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_strobe && sprite_en && !dma_active && !pend && {1'b0, y_pos} == raster_line &&
     x_pos >= 9'(X_SAME_LINE)) |=> (disp_en && !dma_active)); // R4
endmodule

bind sprite_fetch_slot sprite_fetch_slot_chk #(
  .SPR_IDX     (SPR_IDX),
  .X_SAME_LINE (X_SAME_LINE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sprite_en   (sprite_en),
  .x_pos       (x_pos),
  .y_pos       (y_pos),
  .raster_line (raster_line),
  .cmp_strobe  (cmp_strobe),
  .slot_go     (slot_go),
  .bank_sel    (bank_sel),
  .vm_base     (vm_base),
  .mem_rd      (mem_rd),
  .mem_addr    (mem_addr),
  .bus_owner   (bus_owner),
  .dma_active  (dma_active),
  .disp_en     (disp_en),
  .load_strobe (load_strobe),
  .pend        (u_ctrl.pend_q)
);

// File: tb/sprite_fetch_slot_bench.sv
module sprite_fetch_slot_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sprite_en = 1'b0, y_expand = 1'b0;
  logic [8:0]  x_pos = '0, raster_line = '0;
  logic [7:0]  y_pos = 8'hFF;
  logic        line_start = 1'b0, cmp_strobe = 1'b0, slot_go = 1'b0;
  logic [1:0]  bank_sel = 2'b01;
  logic [3:0]  vm_base = 4'h2;
  logic [7:0]  bus_float = 8'hFF;
  logic        mem_rd, bus_owner, dma_active, disp_en, load_strobe;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [23:0] sprite_data;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [23:0] exp_q[$];

  always #4 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[13:8], a[15:14]};
  endfunction

  assign mem_rdata = memf(mem_addr);

  sprite_fetch_slot u_sprite_fetch_slot (
    .clk(clk), .rst_n(rst_n), .sprite_en(sprite_en), .y_expand(y_expand),
    .x_pos(x_pos), .y_pos(y_pos), .raster_line(raster_line),
    .line_start(line_start), .cmp_strobe(cmp_strobe), .slot_go(slot_go),
    .bank_sel(bank_sel), .vm_base(vm_base), .bus_float(bus_float),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .bus_owner(bus_owner), .dma_active(dma_active), .disp_en(disp_en),
    .load_strobe(load_strobe), .sprite_data(sprite_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops the scoreboard on every load (R6, R7, R8)
  always @(negedge clk) begin
    if (rst_n && load_strobe) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected load", {8'h0, sprite_data}, 32'h0);
      else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk(sprite_data == e, "R6/R7 loaded data", {8'h0, sprite_data}, {8'h0, e});
      end
    end
  end

  function automatic logic [15:0] ptr_addr();
    return {bank_sel, vm_base, 10'h3F8};
  endfunction

  function automatic logic [15:0] dat_addr(input logic [7:0] p, input logic [5:0] c);
    return {bank_sel, p, c};
  endfunction

  task automatic pulse_cmp();
    cmp_strobe = 1'b1;
    @(negedge clk); cmp_strobe = 1'b0; #1;
  endtask

  task automatic new_line();
    raster_line = raster_line + 9'd1;
    line_start = 1'b1;
    @(negedge clk); line_start = 1'b0; #1;
  endtask

  task automatic run_slot(input bit dmae, input bit ld, input logic [7:0] f1, input logic [7:0] f3,
                          input logic [5:0] c0);
    logic [7:0]  p;
    logic [15:0] idle;
    p    = memf(ptr_addr());
    idle = {bank_sel, 14'h3FFF};
    if (ld) exp_q.push_back(dmae ? {memf(dat_addr(p, c0)), memf(dat_addr(p, 6'(c0 + 1))),
                                    memf(dat_addr(p, 6'(c0 + 2)))}
                                 : {f1, memf(idle), f3});
    @(negedge clk); slot_go = 1'b1; #1;
    chk(mem_rd && bus_owner && mem_addr == ptr_addr(), "R2 pointer read", {15'h0, mem_rd, mem_addr}, {16'h1, ptr_addr()});
    @(negedge clk); slot_go = 1'b0; bus_float = f1; #1;
    if (dmae) chk(bus_owner && mem_rd && mem_addr == dat_addr(p, c0), "R7 half1", {16'h0, mem_addr}, {16'h0, dat_addr(p, c0)});
    else      chk(!bus_owner && !mem_rd, "R5 half1 processor", {30'h0, bus_owner, mem_rd}, 32'h0);
    @(negedge clk); bus_float = 8'hFF; #1;
    if (dmae) chk(mem_rd && mem_addr == dat_addr(p, 6'(c0 + 1)), "R7 half2", {16'h0, mem_addr}, {16'h0, dat_addr(p, 6'(c0 + 1))});
    else      chk(mem_rd && mem_addr == idle, "R5 idle read", {16'h0, mem_addr}, {16'h0, idle});
    @(negedge clk); bus_float = f3; #1;
    if (dmae) chk(bus_owner && mem_rd && mem_addr == dat_addr(p, 6'(c0 + 2)), "R7 half3", {16'h0, mem_addr}, {16'h0, dat_addr(p, 6'(c0 + 2))});
    else      chk(!bus_owner && !mem_rd, "R5 half3 processor", {30'h0, bus_owner, mem_rd}, 32'h0);
    @(negedge clk); bus_float = 8'hFF; #1;
    chk(load_strobe == ld, "R8 strobe timing", {31'h0, load_strobe}, {31'h0, ld});
    @(negedge clk); #1;
    chk(!load_strobe, "R8 single pulse", {31'h0, load_strobe}, 32'h0);
  endtask

  task automatic run_dma(input bit yexp, input string req);
    int total;
    logic [5:0] c;
    bit rep;
    total = yexp ? 42 : 21;
    c = '0;
    rep = 0;
    for (int i = 0; i < total; i++) begin
      run_slot(1'b1, 1'b1, 8'hFF, 8'hFF, c);
      if (yexp && !rep) rep = 1;
      else begin rep = 0; c = 6'(c + 3); end
      if (i < total - 1) chk(dma_active && disp_en, req, {30'h0, dma_active, disp_en}, 32'h3);
      else               chk(!dma_active && !disp_en, req, {30'h0, dma_active, disp_en}, 32'h0);
      new_line();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(!disp_en && !dma_active && !load_strobe, "R1 reset flags", {29'h0, disp_en, dma_active, load_strobe}, 32'h0);
    chk(sprite_data == 24'h0, "R1 reset data", {8'h0, sprite_data}, 32'h0);

    // Idle slot: no display, no load (R2, R5, R8)
    run_slot(1'b0, 1'b0, 8'hFF, 8'hFF, 6'd0);

    // R11 disabled sprite is not armed
    new_line();
    y_pos = raster_line[7:0];
    pulse_cmp();
    new_line();
    chk(!dma_active && !disp_en, "R11 disabled", {30'h0, dma_active, disp_en}, 32'h0);

    // R3 boundary x = 0x163: display waits for the next line
    sprite_en = 1'b1; x_pos = 9'h163;
    y_pos = raster_line[7:0];
    pulse_cmp();
    chk(!disp_en && !dma_active, "R3 no same-line start", {30'h0, dma_active, disp_en}, 32'h0);
    run_slot(1'b0, 1'b0, 8'hFF, 8'hFF, 6'd0);
    new_line();
    chk(dma_active && disp_en, "R3 next line start", {30'h0, dma_active, disp_en}, 32'h3);
    run_dma(1'b0, "R9 dma length");

    // R4/R6 x = 0x164 with injected bus values
    x_pos = 9'h164;
    y_pos = raster_line[7:0];
    pulse_cmp();
    chk(disp_en && !dma_active, "R4 same-line display", {30'h0, dma_active, disp_en}, 32'h1);
    run_slot(1'b0, 1'b1, 8'hA5, 8'h3C, 6'd0);
    new_line();
    chk(dma_active, "R4 dma on next line", {31'h0, dma_active}, 32'h1);
    run_dma(1'b0, "R9 dma length after artifact");

    // R6 default floating bus pattern, far right edge
    x_pos = 9'h1F0;
    y_pos = raster_line[7:0];
    pulse_cmp();
    run_slot(1'b0, 1'b1, 8'hFF, 8'hFF, 6'd0);
    new_line();
    run_dma(1'b0, "R9 dma length again");

    // R10 Y expansion
    y_expand = 1'b1; x_pos = 9'h040;
    y_pos = raster_line[7:0];
    pulse_cmp();
    new_line();
    run_dma(1'b1, "R10 expanded length");

    chk(exp_q.size() == 0, "R8 all loads seen", exp_q.size(), 32'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule